// File: doc/BRIEF.md
# Truncated fixed-width unsigned multiplier

This block multiplies two unsigned operands of the same width and returns a result of that width: an approximation of the upper half of the full double-width product. It is built as a parallel carry-save array of AND-gate partial products and full-adder cells, followed by a ripple carry adder. Partial products whose weight falls below column N-1 are never generated, so their adder cells do not exist. The whole column N-1 is still formed and summed. It serves only as a correction term: its carries enter column N and its sum bit is thrown away.

The block is purely combinational and has no clock or reset. The result follows the operands after one propagation delay through the array. Users choose the width through a parameter; widths 4, 6, 8 and 12 are the intended range. The output is never larger than the exact upper half of the product. It falls short of that value by at most a small bound that depends only on the width. This suits datapaths that keep only the top half of a product and can accept a bounded truncation error, in exchange for about half the adder cells.

Top module: `tmul_trunc`

## Requirements
- R1: For operands A and B of width N, let S be the sum of every partial product a_i·b_j·2^(i+j) with i+j ≥ N-1. The result equals floor(S / 2^N) exactly.
- R2: The result never exceeds floor(A·B / 2^N).
- R3: floor(A·B / 2^N) minus the result is at most E(N) = ceil(((N-2)·2^(N-1) + 1) / 2^N). This gives 2 for N=4, 3 for N=6, 4 for N=8 and 6 for N=12.
- R4: If either operand is zero, the result is zero.
- R5: With both operands all ones, the result stays within R3's bound. For N=8, 255×255 gives 251.
- R6: Partial products in column N-1 affect the result only through their carries. For N=8, 1×128 gives 0 and 129×129 gives 65.
- R7: Swapping the two operands gives the same result.
- R8: R1, R2 and R3 hold at widths 4, 6, 8 and 12 set through the width parameter.
- R9: The result depends only on the current operands. It follows an operand change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | Multiplicand, unsigned |
| op_b | input | WIDTH | Multiplier, unsigned |
| prod_hi | output | WIDTH | Approximate upper half of op_a·op_b |

## Verification
The block holds no state between operand changes, so any fault in its internals shows at prod_hi within the same evaluation. A partial product that is wired wrong or stuck moves the result by a power of two for every operand pair that sets that bit. A lost carry inside the array usually shows as an off-by-one, which the exact match against the retained-term model catches. Because the sweeps are exhaustive up to N=8, every such fault in those widths meets an exposing operand pair.

// File: rtl/tmul_pkg.sv
package tmul_pkg;

  // Worst-case shortfall of the truncated result below floor(A*B / 2^w).
  // The dropped columns 0..w-2 hold at most (w-2)*2^(w-1)+1, so the
  // shortfall is that sum divided by 2^w, rounded up.
  function automatic int unsigned trunc_err_bound(input int unsigned w);
    int unsigned dropped_max;
    int unsigned scale;
    dropped_max = (w - 2) * (32'd1 << (w - 1)) + 1;
    scale       = 32'd1 << w;
    return (dropped_max + scale - 1) / scale;
  endfunction

endpackage

// File: rtl/tmul_fa.sv
module tmul_fa (
  input  logic in_x,
  input  logic in_y,
  input  logic in_c,
  output logic sum,
  output logic cout
);

  assign sum  = in_x ^ in_y ^ in_c;
  assign cout = (in_x & in_y) | (in_c & (in_x ^ in_y));

endmodule

// File: rtl/tmul_csa_row.sv
// One carry-save stage: folds one row of partial products into the running
// sum and carry vectors. Bit k is column (N-1)+k of the product.
module tmul_csa_row #(
  parameter int unsigned COLS = 9
) (
  input  logic [COLS-1:0] sum_in,
  input  logic [COLS-1:0] car_in,
  input  logic [COLS-1:0] pp_in,
  output logic [COLS-1:0] sum_out,
  output logic [COLS-1:0] car_out,
  output logic            spill
);

  logic [COLS:0] cell_co;

  assign cell_co[0] = 1'b0;

  genvar k;
  generate
    for (k = 0; k < COLS; k++) begin : g_col
      tmul_fa u_fa (
        .in_x (sum_in[k]),
        .in_y (car_in[k]),
        .in_c (pp_in[k]),
        .sum  (sum_out[k]),
        .cout (cell_co[k+1])
      );
    end
  endgenerate

  assign car_out = cell_co[COLS-1:0];
  assign spill   = cell_co[COLS];

endmodule

// File: rtl/tmul_ripple.sv
// Final carry-propagate adder. Column 0 is the correction column: only its
// carry is formed, and its sum bit never leaves the block.
module tmul_ripple #(
  parameter int unsigned COLS = 9
) (
  input  logic [COLS-1:0] vec_s,
  input  logic [COLS-1:0] vec_c,
  output logic [COLS-2:0] upper,
  output logic            cout
);

  logic [COLS-1:0] rc;

  assign rc[0] = vec_s[0] & vec_c[0];

  genvar k;
  generate
    for (k = 1; k < COLS; k++) begin : g_col
      if (k == COLS - 1) begin : g_top
        tmul_fa u_fa (
          .in_x (vec_s[k]),
          .in_y (vec_c[k]),
          .in_c (rc[k-1]),
          .sum  (upper[k-1]),
          .cout (cout)
        );
      end else begin : g_mid
        tmul_fa u_fa (
          .in_x (vec_s[k]),
          .in_y (vec_c[k]),
          .in_c (rc[k-1]),
          .sum  (upper[k-1]),
          .cout (rc[k])
        );
      end
    end
  endgenerate

  assign rc[COLS-1] = 1'b0;

endmodule

// File: rtl/tmul_trunc.sv
module tmul_trunc
  import tmul_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] prod_hi
);

  localparam int unsigned COLS  = WIDTH + 1;
  localparam int unsigned PW    = 2 * WIDTH;
  localparam int unsigned EBND  = trunc_err_bound(WIDTH);

  // Retained partial products, one row per multiplier bit.
  logic [WIDTH-1:0][COLS-1:0] pp_row;
  logic [WIDTH:0][COLS-1:0]   sum_chain;
  logic [WIDTH:0][COLS-1:0]   car_chain;
  logic [WIDTH-1:0]           row_spill;
  logic                       fin_cout;

  genvar j, k;
  generate
    for (j = 0; j < WIDTH; j++) begin : g_row
      for (k = 0; k < COLS; k++) begin : g_bit
        if ((k + WIDTH - 1 >= j) && (k + WIDTH - 1 - j < WIDTH)) begin : g_and
          assign pp_row[j][k] = op_a[k + WIDTH - 1 - j] & op_b[j];
        end else begin : g_none
          assign pp_row[j][k] = 1'b0;
        end
      end
    end
  endgenerate

  assign sum_chain[0] = '0;
  assign car_chain[0] = '0;

  generate
    for (j = 0; j < WIDTH; j++) begin : g_stage
      tmul_csa_row #(.COLS(COLS)) u_row (
        .sum_in  (sum_chain[j]),
        .car_in  (car_chain[j]),
        .pp_in   (pp_row[j]),
        .sum_out (sum_chain[j+1]),
        .car_out (car_chain[j+1]),
        .spill   (row_spill[j])
      );
    end
  endgenerate

  tmul_ripple #(.COLS(COLS)) u_cpa (
    .vec_s (sum_chain[WIDTH]),
    .vec_c (car_chain[WIDTH]),
    .upper (prod_hi),
    .cout  (fin_cout)
  );

  // Checks relating the ports and internal carries.
  logic [PW-1:0] chk_exact_hi;
  logic [PW-1:0] chk_res;

  always_comb begin
    chk_exact_hi = (PW'(op_a) * PW'(op_b)) >> WIDTH;
    chk_res      = PW'(prod_hi);
    assert_no_spill_R1: assert (row_spill == '0 && fin_cout == 1'b0)
      else $error("carry left the top column");
    assert_zero_operand_R4: assert (!(op_a == '0 || op_b == '0) || prod_hi == '0)
      else $error("zero operand gave nonzero result");
    assert_no_overflow_R2: assert (chk_res <= chk_exact_hi)
      else $error("result exceeds exact upper half");
    assert_err_bound_R3: assert (chk_exact_hi - chk_res <= PW'(EBND))
      else $error("truncation error above bound");
  end

endmodule

// File: tb/tmul_trunc_bench.sv
module tmul_trunc_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0]  a8 = '0, b8 = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [5:0]  a6 = '0, b6 = '0;
  logic [11:0] a12 = '0, b12 = '0;
  logic [7:0]  p8;
  logic [3:0]  p4;
  logic [5:0]  p6;
  logic [11:0] p12;

  tmul_trunc u_tmul_trunc (.op_a(a8), .op_b(b8), .prod_hi(p8));
  tmul_trunc #(.WIDTH(4))  u_tmul_trunc_w4  (.op_a(a4),  .op_b(b4),  .prod_hi(p4));
  tmul_trunc #(.WIDTH(6))  u_tmul_trunc_w6  (.op_a(a6),  .op_b(b6),  .prod_hi(p6));
  tmul_trunc #(.WIDTH(12)) u_tmul_trunc_w12 (.op_a(a12), .op_b(b12), .prod_hi(p12));

  // {op_a, op_b, expected} for WIDTH=8, worked by hand from R1.
  localparam logic [23:0] VEC [10] = '{
    {8'd0,   8'd173, 8'd0},    // R4
    {8'd255, 8'd255, 8'd251},  // R5
    {8'd1,   8'd128, 8'd0},    // R6 single term in column 7
    {8'd129, 8'd129, 8'd65},   // R6 two terms in column 7 carry
    {8'd128, 8'd128, 8'd64},
    {8'd16,  8'd16,  8'd1},
    {8'd2,   8'd128, 8'd1},
    {8'd3,   8'd192, 8'd2},
    {8'd15,  8'd240, 8'd13},
    {8'd240, 8'd15,  8'd13}    // R7 swapped
  };

  function automatic int unsigned model(int unsigned n, int unsigned a, int unsigned b);
    int unsigned s = 0;
    for (int i = 0; i < int'(n); i++)
      for (int j = 0; j < int'(n); j++)
        if (i + j >= int'(n) - 1 && a[i] && b[j]) s += (32'd1 << (i + j));
    return s >> n;
  endfunction

  function automatic int unsigned ebound(int unsigned n);
    return ((n - 2) * (32'd1 << (n - 1)) + 1 + (32'd1 << n) - 1) >> n;
  endfunction

  task automatic check(string req, int unsigned got, int unsigned exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_all(int unsigned n, int unsigned a, int unsigned b, int unsigned got);
    int unsigned ex = (a * b) >> n;
    check("R1/R8 exact model", got, model(n, a, b));
    check("R2 not above exact", (got <= ex) ? 1 : 0, 1);
    check("R3 error bound", (ex - got <= ebound(n)) ? 1 : 0, 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // Starting state: all operands zero.
    check("R4 start zero w8", p8, 0);
    check("R4 start zero w12", p12, 0);

    foreach (VEC[i]) begin
      @(posedge clk);
      a8 = VEC[i][23:16];
      b8 = VEC[i][15:8];
      @(negedge clk);
      check("R1 vector table", p8, VEC[i][7:0]);
    end

    // R9: operand change seen without a clock edge.
    @(posedge clk);
    #1 a8 = 8'd129; b8 = 8'd129;
    #0.5 check("R9 follows operands", p8, 65);
    a8 = 8'd0;
    #0.5 check("R9 R4 follows to zero", p8, 0);

    // Exhaustive N=8, and N=4/N=6 on the matching subset (R8).
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        @(posedge clk);
        a8 = 8'(a); b8 = 8'(b);
        a4 = 4'(a); b4 = 4'(b);
        a6 = 6'(a); b6 = 6'(b);
        @(negedge clk);
        check_all(8, a, b, p8);
        if (a < 16 && b < 16) check_all(4, a, b, p4);
        if (a < 64 && b < 64) check_all(6, a, b, p6);
        if (a == 0 || b == 0) check("R4 zero operand", p8, 0);
      end
    end

    // R7 commutation on a few pairs.
    for (int t = 0; t < 64; t++) begin
      int unsigned x = $urandom & 8'hFF;
      int unsigned y = $urandom & 8'hFF;
      int unsigned r1;
      @(posedge clk); a8 = 8'(x); b8 = 8'(y);
      @(negedge clk); r1 = p8;
      @(posedge clk); a8 = 8'(y); b8 = 8'(x);
      @(negedge clk); check("R7 swap", p8, r1);
    end

    // N=12 random plus corners.
    @(posedge clk); a12 = 12'hFFF; b12 = 12'hFFF;
    @(negedge clk); check_all(12, 4095, 4095, p12);
    check("R5 all ones w12", ((4095 * 4095) >> 12) - p12 <= 6 ? 1 : 0, 1);
    @(posedge clk); a4 = 4'hF; b4 = 4'hF;
    @(negedge clk); check("R5 all ones w4", p4, model(4, 15, 15));
    for (int t = 0; t < 20000; t++) begin
      int unsigned x = $urandom & 12'hFFF;
      int unsigned y = $urandom & 12'hFFF;
      @(posedge clk); a12 = 12'(x); b12 = 12'(y);
      @(negedge clk); check_all(12, x, y, p12);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule